// File: doc/BRIEF.md
# SMBus Indexed Block Register Target

This block is a slave-only SMBus/I2C target that holds a small bank of control registers and hands their contents to on-chip logic as one parallel bus. It listens on SCL and SDA through synchronisers running on a fast system clock. It never drives SCL. It pulls SDA low through a single open-drain enable output.

Every transaction names a starting register. A write then gives a byte count and that many data bytes, which land in consecutive registers. A read first sets the offset with a write header. It then issues a repeated START and the read address. The target answers with a count byte and then streams registers from the offset upward until the master refuses a byte.

The bank holds four read/write registers, each with its own power-up value. Above them sits a fixed identification byte. Every index past that reads as zero.

Top module: `smbreg_top`

## Requirements
- R1: The target acknowledges an address byte whose upper seven bits are 1101110, with the lowest bit selecting read (1) or write (0). Any other address is NACKed, and SDA stays released until the next START.
- R2: In a write, the offset byte and a non-zero count byte N are ACKed. The next N data bytes are ACKed and stored at the offset, offset+1, and so on in order.
- R3: A count byte of zero is NACKed, and no register changes for the rest of that transaction.
- R4: A data byte beyond the count N is NACKed and not stored.
- R5: A read (write header with offset, repeated START, address with read bit) first returns the count byte 0x05. It then returns registers from the offset upward, and releases SDA after the master NACKs a byte.
- R6: After reset, cfgBank reads 0x0000FF07, where register i occupies bits [8i+7:8i]. This gives register 0 = 0x07, register 1 = 0xFF, registers 2 and 3 = 0x00.
- R7: Index 4 reads 0x20 and ignores writes. Indices 5 and above read 0x00 and ignore writes.
- R8: A START arriving mid-frame abandons the frame and returns to the address phase. A STOP returns to idle. SDA is released on the cycle after either.
- R9: The target changes its SDA drive only while SCL is low, apart from releasing SDA on START or STOP.
- R10: cfgBank changes only on the cycle after an accepted data byte completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | SCL line level |
| sdaIn | input | 1 | SDA line level |
| sdaDriveLow | output | 1 | 1 pulls SDA low, 0 releases it |
| cfgBank | output | 32 | Read/write registers, register i at bits [8i+7:8i] |

## Verification
At the eighth SCL rise of a data byte, the target stores the byte and decides ACK or NACK from the remaining count, both in the same system cycle. The bench provokes this by sending one byte more than the declared count. It judges the result from three things: the ACK on the last counted byte, the NACK on the surplus byte, and the registers on both sides of the burst read back over the bus and on cfgBank. A zero count and a START dropped in the middle of a data phase put pressure on the same decision from the other side.

// File: rtl/smbreg_pkg.sv
package smbreg_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_OFFS,
    PH_CNT,
    PH_WDATA,
    PH_RCNT,
    PH_RDATA,
    PH_SKIP
  } phase_e;

  // strobes from the sequencer to the register bank
  typedef struct packed {
    logic       wr;
    logic [7:0] idx;
    logic [7:0] wdata;
  } regStb_t;

endpackage

// File: rtl/smbreg_linesync.sv
module smbreg_linesync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sclLvl,
  output logic sdaLvl,
  output logic sclRise,
  output logic sclFall,
  output logic startEv,
  output logic stopEv
);
  localparam int PW = SYNC_STAGES + 1;

  logic [PW-1:0] sclPipe, sdaPipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
    end else begin
      sclPipe <= {sclPipe[PW-2:0], sclIn};
      sdaPipe <= {sdaPipe[PW-2:0], sdaIn};
    end
  end

  logic sclPrev, sdaPrev;
  assign sclLvl  = sclPipe[SYNC_STAGES-1];
  assign sdaLvl  = sdaPipe[SYNC_STAGES-1];
  assign sclPrev = sclPipe[SYNC_STAGES];
  assign sdaPrev = sdaPipe[SYNC_STAGES];

  assign sclRise = sclLvl & ~sclPrev;
  assign sclFall = ~sclLvl & sclPrev;
  assign startEv = sclLvl & sclPrev & ~sdaLvl & sdaPrev;
  assign stopEv  = sclLvl & sclPrev & sdaLvl & ~sdaPrev;
endmodule

// File: rtl/smbreg_ctrl.sv
module smbreg_ctrl
  import smbreg_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR  = 7'b1101110,
  parameter int         REG_COUNT = 5
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sdaLvl,
  input  logic       sclRise,
  input  logic       sclFall,
  input  logic       startEv,
  input  logic       stopEv,
  input  logic [7:0] rdByte,
  output regStb_t    regStb,
  output logic       sdaDriveLow
);
  localparam logic [7:0] CNT_REPLY = 8'(REG_COUNT);

  phase_e     phase, nextPh;
  logic [3:0] bitCnt;
  logic [7:0] rxSh, txSh, ptr, remain;
  logic       ackOut;
  logic [7:0] rxByte;
  logic       txMode, byteDone, active;

  assign rxByte   = {rxSh[6:0], sdaLvl};
  assign txMode   = (phase == PH_RCNT) || (phase == PH_RDATA);
  assign active   = (phase != PH_IDLE) && (phase != PH_SKIP);
  assign byteDone = active && sclRise && (bitCnt == 4'd7) && !txMode;

  assign regStb.wr    = byteDone && (phase == PH_WDATA) && (remain != 8'd0);
  assign regStb.idx   = ptr;
  assign regStb.wdata = rxByte;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase       <= PH_IDLE;
      nextPh      <= PH_IDLE;
      bitCnt      <= '0;
      rxSh        <= '0;
      txSh        <= '0;
      ptr         <= '0;
      remain      <= '0;
      ackOut      <= 1'b0;
      sdaDriveLow <= 1'b0;
    end else if (startEv) begin
      phase       <= PH_ADDR;
      bitCnt      <= '0;
      ackOut      <= 1'b0;
      sdaDriveLow <= 1'b0;
    end else if (stopEv) begin
      phase       <= PH_IDLE;
      bitCnt      <= '0;
      ackOut      <= 1'b0;
      sdaDriveLow <= 1'b0;
    end else if (!active) begin
      if (sclFall) sdaDriveLow <= 1'b0;
    end else if (sclRise) begin
      if (bitCnt == 4'd8) begin
        // acknowledge slot finishes
        bitCnt <= '0;
        if (txMode) begin
          if (sdaLvl) begin
            phase <= PH_SKIP;                  // master refused the byte
          end else begin
            phase <= PH_RDATA;
            txSh  <= rdByte;
            ptr   <= ptr + 8'd1;
          end
        end else begin
          phase <= nextPh;
          if (nextPh == PH_RCNT) txSh <= CNT_REPLY;
        end
      end else begin
        bitCnt <= bitCnt + 4'd1;
        rxSh   <= rxByte;
        if (txMode) txSh <= {txSh[6:0], 1'b0};
        if (byteDone) begin
          ackOut <= 1'b0;
          nextPh <= PH_SKIP;
          case (phase)
            PH_ADDR: if (rxByte[7:1] == DEV_ADDR) begin
              ackOut <= 1'b1;
              nextPh <= rxByte[0] ? PH_RCNT : PH_OFFS;
            end
            PH_OFFS: begin
              ackOut <= 1'b1;
              ptr    <= rxByte;
              nextPh <= PH_CNT;
            end
            PH_CNT: if (rxByte != 8'd0) begin
              ackOut <= 1'b1;
              remain <= rxByte;
              nextPh <= PH_WDATA;
            end
            PH_WDATA: if (remain != 8'd0) begin
              ackOut <= 1'b1;
              remain <= remain - 8'd1;
              ptr    <= ptr + 8'd1;
              nextPh <= PH_WDATA;
            end
            default: ;
          endcase
        end
      end
    end else if (sclFall) begin
      if (bitCnt == 4'd8) sdaDriveLow <= txMode ? 1'b0 : ackOut;
      else                sdaDriveLow <= txMode ? ~txSh[7] : 1'b0;
    end
  end
endmodule

// File: rtl/smbreg_bank.sv
module smbreg_bank
  import smbreg_pkg::*;
#(
  parameter int                    RW_REGS  = 4,
  parameter logic [RW_REGS*8-1:0]  RST_VALS = 32'h0000FF07,
  parameter logic [7:0]            ID_VALUE = 8'h20
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  regStb_t              regStb,
  output logic [7:0]           rdByte,
  output logic [RW_REGS*8-1:0] bankOut
);
  localparam logic [7:0] ID_IDX = 8'(RW_REGS);

  logic [RW_REGS*8-1:0] bankQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bankQ <= RST_VALS;
    end else if (regStb.wr) begin
      for (int i = 0; i < RW_REGS; i++)
        if (regStb.idx == 8'(i)) bankQ[8*i +: 8] <= regStb.wdata;
    end
  end

  always_comb begin
    rdByte = 8'h00;
    if (regStb.idx == ID_IDX) rdByte = ID_VALUE;
    for (int i = 0; i < RW_REGS; i++)
      if (regStb.idx == 8'(i)) rdByte = bankQ[8*i +: 8];
  end

  assign bankOut = bankQ;
endmodule

// File: rtl/smbreg_top.sv
module smbreg_top
  import smbreg_pkg::*;
#(
  parameter logic [6:0]           DEV_ADDR    = 7'b1101110,
  parameter int                   SYNC_STAGES = 2,
  parameter int                   RW_REGS     = 4,
  parameter logic [RW_REGS*8-1:0] RST_VALS    = 32'h0000FF07,
  parameter logic [7:0]           ID_VALUE    = 8'h20
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sclIn,
  input  logic                 sdaIn,
  output logic                 sdaDriveLow,
  output logic [RW_REGS*8-1:0] cfgBank
);
  localparam int REG_COUNT = RW_REGS + 1;

  logic    sclLvl, sdaLvl, sclRise, sclFall, startEv, stopEv;
  logic [7:0] rdByte;
  regStb_t regStb;

  smbreg_linesync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .sclLvl(sclLvl), .sdaLvl(sdaLvl), .sclRise(sclRise), .sclFall(sclFall),
    .startEv(startEv), .stopEv(stopEv)
  );

  smbreg_ctrl #(.DEV_ADDR(DEV_ADDR), .REG_COUNT(REG_COUNT)) u_ctrl (
    .clk(clk), .rstN(rstN), .sdaLvl(sdaLvl), .sclRise(sclRise), .sclFall(sclFall),
    .startEv(startEv), .stopEv(stopEv), .rdByte(rdByte),
    .regStb(regStb), .sdaDriveLow(sdaDriveLow)
  );

  smbreg_bank #(.RW_REGS(RW_REGS), .RST_VALS(RST_VALS), .ID_VALUE(ID_VALUE)) u_bank (
    .clk(clk), .rstN(rstN), .regStb(regStb), .rdByte(rdByte), .bankOut(cfgBank)
  );
endmodule

// File: rtl/smbreg_chk.sv
module smbreg_chk #(
  parameter int BANK_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              sclLvl,
  input logic              startEv,
  input logic              stopEv,
  input logic              wrStb,
  input logic              sdaDriveLow,
  input logic [BANK_W-1:0] cfgBank
);
  AST_RELEASE_ON_STOP: assert property (@(posedge clk) disable iff (!rstN)
    stopEv |=> !sdaDriveLow); // R8

  AST_RELEASE_ON_START: assert property (@(posedge clk) disable iff (!rstN)
    startEv |=> !sdaDriveLow); // R8

  AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaDriveLow) |-> (!sclLvl || $past(startEv || stopEv))); // R9

  AST_BANK_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(cfgBank) |-> $past(wrStb)); // R10

  AST_WRITE_WHILE_RELEASED: assert property (@(posedge clk) disable iff (!rstN)
    wrStb |-> !sdaDriveLow); // R2
endmodule

bind smbreg_top smbreg_chk #(.BANK_W(RW_REGS * 8)) u_chk (
  .clk(clk), .rstN(rstN), .sclLvl(sclLvl), .startEv(startEv), .stopEv(stopEv),
  .wrStb(regStb.wr), .sdaDriveLow(sdaDriveLow), .cfgBank(cfgBank)
);

// File: tb/sim_smbreg_top.sv
module sim_smbreg_top;
  localparam int Q = 10;
  localparam logic [7:0] AW = 8'hDC, AR = 8'hDD;
  // {offset, written value, expected readback}
  localparam logic [23:0] VEC [6] = '{
    {8'h00, 8'hA5, 8'hA5}, {8'h01, 8'h3C, 8'h3C}, {8'h02, 8'h81, 8'h81},
    {8'h03, 8'h5A, 8'h5A}, {8'h04, 8'h13, 8'h20}, {8'h06, 8'h77, 8'h00}
  };

  logic clk = 1'b0, rstN = 1'b0, sclIn = 1'b1, mSdaLow = 1'b0;
  logic sdaDriveLow, sdaLine;
  logic [31:0] cfgBank;
  int checks = 0, errors = 0, r9Viol = 0;
  bit done = 1'b0;
  logic prevDrive = 1'b0;

  always #2 clk = ~clk;
  assign sdaLine = !(mSdaLow || sdaDriveLow);

  smbreg_top u0 (.clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaLine),
                 .sdaDriveLow(sdaDriveLow), .cfgBank(cfgBank));

  // R9 port monitor: target drive must not move while SCL is high
  always @(negedge clk) begin
    if (rstN && sclIn && (sdaDriveLow != prevDrive)) r9Viol++;
    prevDrive <= sdaDriveLow;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitQ; repeat (Q) @(negedge clk); endtask

  task automatic bitCycle(input logic drv, output logic seen);
    mSdaLow = !drv; waitQ; sclIn = 1'b1; waitQ; seen = sdaLine; waitQ; sclIn = 1'b0; waitQ;
  endtask

  task automatic doStart;
    mSdaLow = 1'b0; waitQ; sclIn = 1'b1; waitQ; mSdaLow = 1'b1; waitQ; sclIn = 1'b0; waitQ;
  endtask

  task automatic doStop;
    mSdaLow = 1'b1; waitQ; sclIn = 1'b1; waitQ; mSdaLow = 1'b0; waitQ; waitQ;
  endtask

  task automatic sendByte(input logic [7:0] b, output logic acked);
    logic s;
    for (int i = 7; i >= 0; i--) bitCycle(b[i], s);
    bitCycle(1'b1, s);
    acked = !s;
  endtask

  task automatic recvByte(input logic mAck, output logic [7:0] b);
    logic s;
    b = '0;
    for (int i = 0; i < 8; i++) begin bitCycle(1'b1, s); b = {b[6:0], s}; end
    bitCycle(!mAck, s);
  endtask

  // ackVec bit0 address, bit1 offset, bit2 count, bit3.. data bytes
  task automatic doWrite(input logic [7:0] adr, input logic [7:0] off, input logic [7:0] cnt,
                         input logic [63:0] d, input int nSend, output logic [11:0] ackVec);
    logic a;
    ackVec = '0;
    doStart;
    sendByte(adr, a); ackVec[0] = a;
    sendByte(off, a); ackVec[1] = a;
    sendByte(cnt, a); ackVec[2] = a;
    for (int k = 0; k < nSend; k++) begin sendByte(d[8*k +: 8], a); ackVec[3+k] = a; end
    doStop;
  endtask

  task automatic doRead(input logic [7:0] off, input int nRead,
                        output logic [7:0] cntByte, output logic [63:0] d);
    logic a;
    logic [7:0] b;
    d = '0;
    doStart; sendByte(AW, a); sendByte(off, a);
    doStart; sendByte(AR, a);
    recvByte(1'b1, cntByte);
    for (int k = 0; k < nRead; k++) begin recvByte(k != nRead - 1, b); d[8*k +: 8] = b; end
    doStop;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [11:0] acks;
    logic [7:0]  cnt;
    logic [63:0] d;
    logic        a;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (5) @(negedge clk);

    // R6 reset state
    chk("R6 reset bank", cfgBank, 32'h0000FF07);
    chk("R6 sda released", sdaDriveLow, 1'b0);
    doRead(8'h04, 1, cnt, d);
    chk("R6 id byte", d[7:0], 8'h20);
    chk("R5 count byte", cnt, 8'h05);

    // table walk: single-byte write then read back
    for (int v = 0; v < 6; v++) begin
      doWrite(AW, VEC[v][23:16], 8'd1, {56'd0, VEC[v][15:8]}, 1, acks);
      chk("R2 write acks", acks[3:0], 4'hF);
      doRead(VEC[v][23:16], 1, cnt, d);
      chk("R5 read count", cnt, 8'h05);
      chk("R7 readback", d[7:0], VEC[v][7:0]);
      if (VEC[v][23:16] < 8'd4) chk("R2 bank field", cfgBank[8*VEC[v][19:16] +: 8], VEC[v][7:0]);
    end

    // R2 block write with auto-increment; R5 block read
    doWrite(AW, 8'h01, 8'd3, 64'h332211, 3, acks);
    chk("R2 block acks", acks[5:0], 6'h3F);
    chk("R2 bank after block", cfgBank, 32'h332211A5);
    doRead(8'h00, 4, cnt, d);
    chk("R5 block read", d[31:0], 32'h332211A5);
    doRead(8'h03, 3, cnt, d);
    chk("R7 read across id and empty", d[23:0], 24'h002033);

    // R3 zero count
    doWrite(AW, 8'h02, 8'd0, 64'hEE, 1, acks);
    chk("R3 count nacked", acks[2], 1'b0);
    chk("R3 data nacked", acks[3], 1'b0);
    chk("R3 bank unchanged", cfgBank, 32'h332211A5);

    // R4 surplus byte
    doWrite(AW, 8'h00, 8'd1, 64'h9944, 2, acks);
    chk("R4 counted byte acked", acks[3], 1'b1);
    chk("R4 surplus nacked", acks[4], 1'b0);
    chk("R4 bank", cfgBank, 32'h33221144);

    // R1 foreign address
    doWrite(8'hB8, 8'h00, 8'd1, 64'h00, 1, acks);
    chk("R1 foreign address nacked", acks[3:0], 4'h0);
    chk("R1 bank unchanged", cfgBank, 32'h33221144);

    // R8 START in the middle of a data phase
    doStart;
    sendByte(AW, a); sendByte(8'h00, a); sendByte(8'd2, a); sendByte(8'h12, a);
    doStart;
    sendByte(AW, a);
    chk("R8 address after restart acked", a, 1'b1);
    sendByte(8'h02, a); sendByte(8'd1, a); sendByte(8'h5E, a);
    doStop;
    chk("R8 abandoned frame", cfgBank, 32'h335E1112);
    chk("R8 released after stop", sdaDriveLow, 1'b0);

    chk("R9 drive moved with SCL high", r9Viol, 0);
    // R10 covered by AST_BANK_ONLY_ON_WRITE and the unchanged-bank checks above

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule